// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between the fetch logic of a byte-oriented processor core and a 16-bit memory bus. The fetch side writes whole bus words into a small ring of byte slots. A flag on the word marks that only its upper byte belongs to the instruction stream, which happens when a fetch starts at an odd address. The execution side reads the three oldest bytes at once and retires one, two or three of them in a single clock. An opcode byte is therefore taken on its own, and a 16- or 24-bit operand field is taken in one step.

The ring holds five bytes, one more than the longest instruction. The block reports its occupancy and its free slots so the fetch logic knows when to issue the next bus word. A flush empties the ring in one cycle. It is used after a taken branch and for an explicit flush instruction. The block never watches stores, so code that rewrites bytes already prefetched needs an explicit flush.

Top module: `prefetch_byte_queue`

## Requirements
- R1: After reset the queue is empty: occupancy 0, free_slots 5, peek_valid 0 and all peek bytes 0.
- R2: A fill without the upper-only flag is accepted only when at least 2 slots are free. Its bits [7:0] then become the older byte and its bits [15:8] the younger byte.
- R3: A fill with fill_hi_only set is accepted when at least 1 slot is free, and only bits [15:8] are stored.
- R4: A fill offered while fill_ready is low leaves the occupancy and the head bytes unchanged.
- R5: A pop_count of 1, 2 or 3 that does not exceed the occupancy asserts pop_ok and removes that many head bytes in one clock. A pop_count of 0 removes nothing.
- R6: A pop_count larger than the occupancy is refused. pop_ok stays low, and the head bytes and the occupancy stay unchanged, apart from any accepted fill in that cycle.
- R7: A fill and a pop may both happen in one cycle. The new occupancy is the old occupancy, plus the bytes written, minus the bytes popped. Fill room is judged on the occupancy before that cycle's pop.
- R8: flush wins over a fill or pop in the same cycle. While flush is high, fill_ready and pop_ok are low, and on the next clock the occupancy is 0.
- R9: peek_bytes shows the three oldest bytes in program order, with the oldest in bits [7:0]. Slots beyond the valid count read 0, and peek_valid equals the smaller of the occupancy and 3.
- R10: free_slots always equals 5 minus the occupancy, and the occupancy never exceeds 5.
- R11: A long mixed stream of fills, pops and flushes comes out in the same byte order it went in, across pointer wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all queued bytes |
| fill_valid | input | 1 | A fetch word is offered |
| fill_word | input | 16 | Fetch word; the lower byte is the older one |
| fill_hi_only | input | 1 | Only bits [15:8] of the word are instruction bytes |
| fill_ready | output | 1 | The offered word would be accepted this cycle |
| pop_count | input | 2 | Number of head bytes to retire (0 to 3) |
| pop_ok | output | 1 | The requested pop is carried out this cycle |
| peek_bytes | output | 24 | The three head bytes, oldest in [7:0] |
| peek_valid | output | 2 | How many peek bytes are valid |
| occupancy | output | 3 | Bytes held |
| free_slots | output | 3 | Empty byte slots |

## Verification
Directed steps first fill the ring with whole words until a word no longer fits. An upper-only word is then placed into the one remaining slot. This separates the two room rules and shows the order of the two halves of a word. Next come pops of each size, including requests larger than the occupancy, which separates legal retirement from refusal. Same-cycle fill and pop, and a flush issued together with both, show the count arithmetic and the flush priority. A long random stream then runs the pointers through many wraparounds against a behavioural byte list, so any reordering, loss or duplication of bytes appears in the peeked head.

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue #(
  parameter int DEPTH = 5,
  parameter int PEEK  = 3,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(PEEK + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            fill_valid,
  input  logic [15:0]     fill_word,
  input  logic            fill_hi_only,
  output logic            fill_ready,
  input  logic [NW-1:0]   pop_count,
  output logic            pop_ok,
  output logic [8*PEEK-1:0] peek_bytes,
  output logic [NW-1:0]   peek_valid,
  output logic [CW-1:0]   occupancy,
  output logic [CW-1:0]   free_slots
);

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int unsigned n);
    int unsigned s;
    s = int'(p) + n;
    return PW'(s >= DEPTH ? s - DEPTH : s);
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] occ;

  wire [CW-1:0] free     = CW'(DEPTH) - occ;
  wire          room     = fill_hi_only ? (free >= CW'(1)) : (free >= CW'(2));
  assign fill_ready      = room & ~flush;
  wire          fill_take = fill_valid & fill_ready;
  assign pop_ok          = ~flush && (pop_count != '0) && (CW'(pop_count) <= occ);

  wire [CW-1:0] n_in  = fill_take ? (fill_hi_only ? CW'(1) : CW'(2)) : '0;
  wire [CW-1:0] n_out = pop_ok ? CW'(pop_count) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      occ    <= occ + n_in - n_out;
      rd_ptr <= adv(rd_ptr, int'(n_out));
      wr_ptr <= adv(wr_ptr, int'(n_in));
    end
  end

  always_ff @(posedge clk) begin
    if (fill_take) begin
      if (fill_hi_only) begin
        mem[wr_ptr] <= fill_word[15:8];
      end else begin
        mem[wr_ptr]         <= fill_word[7:0];
        mem[adv(wr_ptr, 1)] <= fill_word[15:8];
      end
    end
  end

  for (genvar g = 0; g < PEEK; g++) begin : g_peek
    assign peek_bytes[8*g +: 8] = (occ > CW'(g)) ? mem[adv(rd_ptr, g)] : 8'h00;
  end

  assign peek_valid = (occ >= CW'(PEEK)) ? NW'(PEEK) : NW'(occ);
  assign occupancy  = occ;
  assign free_slots = free;

endmodule

// File: rtl/prefetch_byte_queue_chk.sv
module prefetch_byte_queue_chk #(
  parameter int DEPTH = 5,
  parameter int PEEK  = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(PEEK + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              fill_valid,
  input logic              fill_hi_only,
  input logic              fill_ready,
  input logic [NW-1:0]     pop_count,
  input logic              pop_ok,
  input logic [8*PEEK-1:0] peek_bytes,
  input logic [NW-1:0]     peek_valid,
  input logic [CW-1:0]     occupancy,
  input logic [CW-1:0]     free_slots
);

  wire [CW:0] wrote  = (fill_valid && fill_ready) ? (fill_hi_only ? (CW+1)'(1) : (CW+1)'(2)) : '0;
  wire [CW:0] popped = pop_ok ? (CW+1)'(pop_count) : '0;

  assert_occ_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH);

  assert_word_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ready && !fill_hi_only) |-> int'(free_slots) >= 2);

  assert_hi_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ready && fill_hi_only) |-> int'(free_slots) >= 1);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0) && (peek_valid == '0));

  assert_refused_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && pop_count != '0 && int'(pop_count) > int'(occupancy) && !(fill_valid && fill_ready))
    |=> (occupancy == $past(occupancy)) && (peek_bytes == $past(peek_bytes)));

  assert_balance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(occupancy) == int'($past(occupancy)) + int'($past(wrote)) - int'($past(popped)));

endmodule

bind prefetch_byte_queue prefetch_byte_queue_chk #(.DEPTH(DEPTH), .PEEK(PEEK)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .fill_hi_only(fill_hi_only), .fill_ready(fill_ready), .pop_count(pop_count),
  .pop_ok(pop_ok), .peek_bytes(peek_bytes), .peek_valid(peek_valid),
  .occupancy(occupancy), .free_slots(free_slots)
);

// File: tb/tb_prefetch_byte_queue.sv
module tb_prefetch_byte_queue;
  logic        clk = 0;
  logic        rst_n, flush, fill_valid, fill_hi_only;
  logic [15:0] fill_word;
  logic        fill_ready, pop_ok;
  logic [1:0]  pop_count, peek_valid;
  logic [23:0] peek_bytes;
  logic [2:0]  occupancy, free_slots;

  always #2 clk = ~clk;

  prefetch_byte_queue dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
    .fill_word(fill_word), .fill_hi_only(fill_hi_only), .fill_ready(fill_ready),
    .pop_count(pop_count), .pop_ok(pop_ok), .peek_bytes(peek_bytes),
    .peek_valid(peek_valid), .occupancy(occupancy), .free_slots(free_slots)
  );

  byte unsigned q[$];
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit fv, logic [15:0] w, bit hi, int pc, bit fl);
    int  occ;
    bit  room, exp_fr, exp_po;
    @(negedge clk);
    fill_valid = fv; fill_word = w; fill_hi_only = hi; pop_count = 2'(pc); flush = fl;
    #1;
    occ    = q.size();
    room   = hi ? (5 - occ >= 1) : (5 - occ >= 2);
    exp_fr = room && !fl;
    exp_po = !fl && pc != 0 && pc <= occ;
    chk("R10 occupancy", occupancy, occ);
    chk("R10 free_slots", free_slots, 5 - occ);
    chk("R2/R3 fill_ready", fill_ready, exp_fr);
    chk("R5/R6 pop_ok", pop_ok, exp_po);
    chk("R9 peek_valid", peek_valid, occ < 3 ? occ : 3);
    for (int i = 0; i < 3; i++)
      chk("R9 peek byte", peek_bytes[8*i +: 8], i < occ ? q[i] : 0);
    if (fl) q.delete();
    else begin
      if (exp_po) for (int i = 0; i < pc; i++) void'(q.pop_front());
      if (fv && exp_fr) begin
        if (!hi) q.push_back(w[7:0]);
        q.push_back(w[15:8]);
      end
    end
  endtask

  initial begin
    #400us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; flush = 0; fill_valid = 0; fill_word = 0; fill_hi_only = 0; pop_count = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R1";  step(0, 16'h0, 0, 0, 0);
    tag = "R2";  step(1, 16'h2211, 0, 0, 0); step(1, 16'h4433, 0, 0, 0);
    tag = "R4";  step(1, 16'h6655, 0, 0, 0); step(0, 16'h0, 0, 0, 0);
    tag = "R3";  step(1, 16'h77EE, 1, 0, 0);
    tag = "R4";  step(1, 16'h88EE, 1, 0, 0); step(0, 16'h0, 0, 0, 0);
    tag = "R5";  step(0, 16'h0, 0, 1, 0); step(0, 16'h0, 0, 3, 0); step(0, 16'h0, 0, 0, 0);
    tag = "R6";  step(0, 16'h0, 0, 3, 0); step(0, 16'h0, 0, 2, 0); step(0, 16'h0, 0, 0, 0);
    tag = "R7";  step(1, 16'hBBAA, 0, 1, 0); step(1, 16'hDDCC, 0, 2, 0); step(1, 16'hFFEE, 1, 1, 0);
    tag = "R8";  step(1, 16'h1234, 0, 1, 1); step(0, 16'h0, 0, 0, 0);
    tag = "R11";
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 3) != 0, 16'($urandom), $urandom_range(0, 3) == 0,
           $urandom_range(0, 3), $urandom_range(0, 31) == 0);
    step(0, 16'h0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule